// File: doc/BRIEF.md
# Trap entry sequencer

This block carries out the processor-state update when a register-window processor accepts a trap. A trap request arrives together with an 8-bit trap number. The state registers live outside the block and are presented to it as current values. The block first copies those values into a snapshot. It then writes the saved program counter and next program counter into locals 1 and 2 of the new window through one register-file write port, on two cycles in a row. In the cycle after that it raises a single commit strobe. The commit strobe comes with the new trap-enable, window pointer, supervisor bits, trap base value and fetch addresses, which the surrounding state registers must load.

The window count is a power of two; its default is 8. If a request arrives while traps are already disabled, the block does not enter the trap. It raises an error-mode output instead, and that output stays high until reset.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset `busy`, `errMode`, `rfWe` and `stWe` are all 0.
- R2: An accepted request is one that is sampled while the block is idle, with `curEt`=1 and `errMode`=0. In the first cycle after an accepted request, `rfWe`=1, `rfWin`=(curCwp-1) mod NWIN, `rfReg`=1 and `rfData`=curPc. `busy` is 1 from that cycle until the end of the commit cycle.
- R3: In the second cycle after acceptance, `rfWe`=1 with the same `rfWin`, `rfReg`=2 and `rfData`=curNpc.
- R4: In the third cycle after acceptance, `stWe`=1 for exactly one cycle, with `rfWe`=0, `newEt`=0 and `newCwp` equal to the window used for the saves.
- R5: During commit, `newPs` equals the supervisor bit captured at acceptance and `newS`=1.
- R6: During commit, `newTbr` keeps bits 31..12 of the captured `curTbr`, holds the trap number in bits 11..4, and has 0 in bits 3..0.
- R7: During commit, `newPc`=`newTbr` and `newNpc`=`newTbr`+4.
- R8: All saved and committed values come from the inputs sampled at acceptance. Changes on the current-state inputs after that have no effect.
- R9: A request that arrives while `busy`=1 is ignored. The cycle after commit shows `rfWe`=0, `stWe`=0 and `busy`=0.
- R10: A request sampled while idle with `curEt`=0 sets `errMode` in the next cycle, with no write and no commit. `errMode` stays set until reset, and every request made while it is set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | Trap request |
| trapNum | input | 8 | Trap number |
| curPc | input | 32 | Current program counter |
| curNpc | input | 32 | Current next program counter |
| curCwp | input | 3 | Current window pointer |
| curS | input | 1 | Current supervisor bit |
| curEt | input | 1 | Current trap-enable bit |
| curTbr | input | 32 | Current trap base register |
| busy | output | 1 | Sequence in progress |
| errMode | output | 1 | Sticky error mode |
| rfWe | output | 1 | Register-file write enable |
| rfWin | output | 3 | Window of the write |
| rfReg | output | 3 | Local register index of the write |
| rfData | output | 32 | Write data |
| stWe | output | 1 | State commit strobe |
| newEt | output | 1 | New trap-enable bit |
| newCwp | output | 3 | New window pointer |
| newS | output | 1 | New supervisor bit |
| newPs | output | 1 | New previous-supervisor bit |
| newTbr | output | 32 | New trap base register |
| newPc | output | 32 | New program counter |
| newNpc | output | 32 | New next program counter |

## Verification
The bench goes after window pointer 0. A design without the modulo wrap would send both saves outside the window set instead of to window 7. Between acceptance and commit it rewrites every current-state input and keeps the request asserted. A design that reads live inputs would save or commit the wrong values, and one that re-arms while busy would start a second sequence. It also sends requests with traps disabled, both directly and after an error. A design that missed this would write registers and commit instead of halting, or would let error mode drop or be overridden.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  typedef struct packed {
    logic capture;
    logic savePc;
    logic saveNpc;
    logic commit;
  } trapStrobes_t;
endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         trapReq,
  input  logic         curEt,
  output trapStrobes_t strb,
  output logic         busy,
  output logic         errMode
);
  typedef enum logic [1:0] {S_IDLE, S_SAVE1, S_SAVE2, S_COMMIT} state_t;
  state_t state, stateNxt;
  logic   errSet;

  always_comb begin
    strb         = '0;
    strb.capture = (state == S_IDLE) && trapReq && curEt && !errMode;
    strb.savePc  = (state == S_SAVE1);
    strb.saveNpc = (state == S_SAVE2);
    strb.commit  = (state == S_COMMIT);
    errSet       = (state == S_IDLE) && trapReq && !curEt && !errMode;
    busy         = (state != S_IDLE);
  end

  always_comb begin
    stateNxt = state;
    case (state)
      S_IDLE:   if (strb.capture) stateNxt = S_SAVE1;
      S_SAVE1:  stateNxt = S_SAVE2;
      S_SAVE2:  stateNxt = S_COMMIT;
      default:  stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      errMode <= 1'b0;
    end else begin
      state <= stateNxt;
      if (errSet) errMode <= 1'b1;
    end
  end

  // R3
  save_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.savePc |=> strb.saveNpc);
  // R4
  commit_after_save_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.saveNpc |=> strb.commit);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errMode |=> errMode);
  // R10
  err_no_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errMode && !busy) |=> !busy);
  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.savePc, strb.saveNpc, strb.commit}));
endmodule

// File: rtl/trap_entry_dp.sv
module trap_entry_dp
  import trap_entry_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int XLEN  = 32,
  parameter int TTW   = 8,
  parameter int TTLSB = 4,
  localparam int CWPW  = $clog2(NWIN),
  localparam int TTMSB = TTLSB + TTW - 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  trapStrobes_t    strb,
  input  logic [TTW-1:0]  trapNum,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] curNpc,
  input  logic [CWPW-1:0] curCwp,
  input  logic            curS,
  input  logic [XLEN-1:0] curTbr,
  output logic            rfWe,
  output logic [CWPW-1:0] rfWin,
  output logic [2:0]      rfReg,
  output logic [XLEN-1:0] rfData,
  output logic            stWe,
  output logic            newEt,
  output logic [CWPW-1:0] newCwp,
  output logic            newS,
  output logic            newPs,
  output logic [XLEN-1:0] newTbr,
  output logic [XLEN-1:0] newPc,
  output logic [XLEN-1:0] newNpc
);
  logic [XLEN-1:0] snapPc, snapNpc, snapTbr;
  logic [CWPW-1:0] snapWin;
  logic            snapS;
  logic [TTW-1:0]  snapTt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapPc  <= '0;
      snapNpc <= '0;
      snapTbr <= '0;
      snapWin <= '0;
      snapS   <= 1'b0;
      snapTt  <= '0;
    end else if (strb.capture) begin
      snapPc  <= curPc;
      snapNpc <= curNpc;
      snapTbr <= curTbr;
      snapWin <= curCwp - 1'b1;
      snapS   <= curS;
      snapTt  <= trapNum;
    end
  end

  always_comb begin
    rfWe   = strb.savePc | strb.saveNpc;
    rfWin  = snapWin;
    rfReg  = strb.savePc ? 3'd1 : 3'd2;
    rfData = strb.savePc ? snapPc : snapNpc;
  end

  always_comb begin
    stWe   = strb.commit;
    newEt  = 1'b0;
    newCwp = snapWin;
    newS   = 1'b1;
    newPs  = snapS;
    newTbr = snapTbr;
    newTbr[TTMSB:TTLSB] = snapTt;
    newTbr[TTLSB-1:0]   = '0;
    newPc  = newTbr;
    newNpc = newTbr + XLEN'(4);
  end

  // R3
  save_window_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.saveNpc |-> $stable(rfWin));
  // R4
  commit_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> newCwp == $past(rfWin));
  // R8
  snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.saveNpc || strb.commit) |-> $stable(newTbr));
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_entry_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  parameter int TTW  = 8,
  localparam int CWPW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trapReq,
  input  logic [TTW-1:0]  trapNum,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] curNpc,
  input  logic [CWPW-1:0] curCwp,
  input  logic            curS,
  input  logic            curEt,
  input  logic [XLEN-1:0] curTbr,
  output logic            busy,
  output logic            errMode,
  output logic            rfWe,
  output logic [CWPW-1:0] rfWin,
  output logic [2:0]      rfReg,
  output logic [XLEN-1:0] rfData,
  output logic            stWe,
  output logic            newEt,
  output logic [CWPW-1:0] newCwp,
  output logic            newS,
  output logic            newPs,
  output logic [XLEN-1:0] newTbr,
  output logic [XLEN-1:0] newPc,
  output logic [XLEN-1:0] newNpc
);
  trapStrobes_t strb;

  trap_entry_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .curEt(curEt),
    .strb(strb), .busy(busy), .errMode(errMode)
  );

  trap_entry_dp #(.NWIN(NWIN), .XLEN(XLEN), .TTW(TTW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .trapNum(trapNum),
    .curPc(curPc), .curNpc(curNpc), .curCwp(curCwp), .curS(curS),
    .curTbr(curTbr), .rfWe(rfWe), .rfWin(rfWin), .rfReg(rfReg),
    .rfData(rfData), .stWe(stWe), .newEt(newEt), .newCwp(newCwp),
    .newS(newS), .newPs(newPs), .newTbr(newTbr), .newPc(newPc),
    .newNpc(newNpc)
  );

  // R2
  write_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> busy);
  // R4
  commit_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    stWe |=> !stWe);
endmodule

// File: tb/trap_entry_seq_bench.sv
module trap_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        trapReq;
  logic [7:0]  trapNum;
  logic [31:0] curPc, curNpc, curTbr;
  logic [2:0]  curCwp;
  logic        curS, curEt;
  logic        busy, errMode, rfWe, stWe, newEt, newS, newPs;
  logic [2:0]  rfWin, rfReg, newCwp;
  logic [31:0] rfData, newTbr, newPc, newNpc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  trap_entry_seq u_trap_entry_seq (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapNum(trapNum),
    .curPc(curPc), .curNpc(curNpc), .curCwp(curCwp), .curS(curS),
    .curEt(curEt), .curTbr(curTbr), .busy(busy), .errMode(errMode),
    .rfWe(rfWe), .rfWin(rfWin), .rfReg(rfReg), .rfData(rfData),
    .stWe(stWe), .newEt(newEt), .newCwp(newCwp), .newS(newS),
    .newPs(newPs), .newTbr(newTbr), .newPc(newPc), .newNpc(newNpc)
  );

  function automatic logic [31:0] expTbr(logic [31:0] tbr, logic [7:0] tt);
    return {tbr[31:12], tt, 4'h0};
  endfunction

  function automatic logic [2:0] expWin(logic [2:0] cwp);
    return (cwp + 3'd7) % 8;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finishRun();
    end
  end

  task automatic scramble();
    curPc  = $urandom;
    curNpc = $urandom;
    curTbr = $urandom;
    curCwp = 3'($urandom);
    curS   = 1'($urandom);
    trapNum = 8'($urandom);
  endtask

  task automatic runTrap(logic [31:0] pc, logic [31:0] npc, logic [2:0] cwp,
                         logic s, logic [31:0] tbr, logic [7:0] tt);
    logic [31:0] eTbr = expTbr(tbr, tt);
    logic [2:0]  eWin = expWin(cwp);
    curPc = pc; curNpc = npc; curCwp = cwp; curS = s; curTbr = tbr;
    trapNum = tt; curEt = 1'b1; trapReq = 1'b1;
    @(negedge clk);
    // R8 / R9: scramble inputs and keep request high while busy
    scramble();
    chk(rfWe && rfReg == 3'd1 && busy, "R2 save1 ctl", {rfWe, busy, 27'd0, rfReg}, {2'b11, 27'd0, 3'd1});
    chk(rfWin == eWin, "R2 window", 32'(rfWin), 32'(eWin));
    chk(rfData == pc, "R2 pc save", rfData, pc);
    @(negedge clk);
    chk(rfWe && rfReg == 3'd2 && rfWin == eWin, "R3 save2 ctl", {rfWe, 25'd0, rfWin, rfReg}, {1'b1, 25'd0, eWin, 3'd2});
    chk(rfData == npc, "R3 npc save (R8)", rfData, npc);
    @(negedge clk);
    trapReq = 1'b0;
    chk(stWe && !rfWe && !newEt && newCwp == eWin, "R4 commit", {stWe, rfWe, newEt, 26'd0, newCwp}, {3'b100, 26'd0, eWin});
    chk(newPs == s && newS, "R5 supervisor", {30'd0, newPs, newS}, {30'd0, s, 1'b1});
    chk(newTbr == eTbr, "R6 tbr (R8)", newTbr, eTbr);
    chk(newPc == eTbr, "R7 pc", newPc, eTbr);
    chk(newNpc == eTbr + 32'd4, "R7 npc", newNpc, eTbr + 32'd4);
    @(negedge clk);
    chk(!stWe && !rfWe && !busy, "R9 idle after", {29'd0, stWe, rfWe, busy}, 32'd0);
  endtask

  initial begin
    process::self().srandom(32'h5EED1234);
    rstN = 1'b0; trapReq = 1'b0; trapNum = '0; curPc = '0; curNpc = '0;
    curCwp = '0; curS = 1'b0; curEt = 1'b1; curTbr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk(!busy && !errMode && !rfWe && !stWe, "R1 reset", {28'd0, busy, errMode, rfWe, stWe}, 32'd0);

    // directed corners: window 0 wrap, all-ones tbr low bits
    runTrap(32'h0000_1000, 32'h0000_1004, 3'd0, 1'b0, 32'hFFFF_FFFF, 8'hFF);
    runTrap(32'h8000_0000, 32'h8000_0004, 3'd7, 1'b1, 32'h4000_0ABC, 8'h00);
    runTrap(32'h1234_5678, 32'h1234_567C, 3'd1, 1'b1, 32'hFFFF_FFF0, 8'hFF);

    for (int i = 0; i < 30; i++) begin
      runTrap($urandom, $urandom, 3'($urandom), 1'($urandom), $urandom, 8'($urandom));
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    // R10: request with traps disabled
    curEt = 1'b0; trapReq = 1'b1;
    @(negedge clk);
    trapReq = 1'b0;
    chk(errMode && !rfWe && !stWe && !busy, "R10 error entry", {28'd0, errMode, rfWe, stWe, busy}, 32'h8);
    @(negedge clk);
    chk(!rfWe && !stWe, "R10 no write", {30'd0, rfWe, stWe}, 32'd0);
    curEt = 1'b1; trapReq = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(errMode && !rfWe && !stWe && !busy, "R10 sticky ignore", {28'd0, errMode, rfWe, stWe, busy}, 32'h8);
    end
    trapReq = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk(!errMode && !busy, "R1 reset clears error", {30'd0, errMode, busy}, 32'd0);
    runTrap(32'hCAFE_0000, 32'hCAFE_0004, 3'd0, 1'b0, 32'h0000_0000, 8'h5A);
    finishRun();
  end
endmodule